// File: doc/BRIEF.md
# Port Direction and Data Registers with Masked Writes and Match Flag

This block keeps the two byte-wide state registers of a general-purpose pin bank. One register holds the value the pins drive. The other holds a per-pin direction. The block turns these registers into pin output enables and pin output values. It also forms the byte that a read returns. A decoded write strobe selects one register and supplies a byte and a two-bit format. The format chooses one of three actions: the byte replaces the register, the byte clears bits under a mask, or the byte sets bits under a mask. Single bits can therefore change without a read-modify-write.

The block also evaluates a match condition between the stored data register and the sampled pin levels. A pin configured as an output always counts as matching. A two-bit compare mode selects one of four conditions: any mismatch, full match, full mismatch, or any match. The result is latched as a flag on a transfer-start pulse. The flag stays fixed for the rest of that transfer.

The surrounding serial front end supplies the strobes. It pulses `mode_load` when a control byte arrives, pulses `xfer_start` when the chip is selected, and presents `pin_in` from the pad synchronisers.

Top module: `pin_bank_ctrl`

## Requirements
- R1: After reset, the direction register, the data register, the match flag and the compare mode are all zero. Every pin is therefore an input, and a data read returns `pin_in`.
- R2: `pin_oe` equals the direction register and `pin_out` equals the data register. Both show a write in the cycle after the write strobe.
- R3: With `rd_sel`=0, each bit of `rd_data` is the data register bit where the direction bit is 1, and the live `pin_in` bit where the direction bit is 0.
- R4: With `rd_sel`=1, `rd_data` is the direction register.
- R5: A write with `wr_fmt`=00 loads `wr_byte` into the selected register.
- R6: A write with `wr_fmt`=10 or 11 clears every register bit where `wr_byte` is 1 and keeps the other bits. For example, 0xAA with mask 0xF0 gives 0x0A.
- R7: A write with `wr_fmt`=01 sets every register bit where `wr_byte` is 1 and keeps the other bits. For example, 0xAA with mask 0xF0 gives 0xFA.
- R8: `wr_sel`=0 selects the data register and `wr_sel`=1 selects the direction register. A write changes only the selected register. With `wr_en` low, neither register changes.
- R9: A bit matches when its direction bit is 1, or when `pin_in` equals the data register bit.
- R10: The flag is 1 exactly when the held mode's condition is true. The modes are: 00, at least one bit does not match; 01, every bit matches; 10, no bit matches; 11, at least one bit matches.
- R11: The flag takes the condition value at the clock edge where `xfer_start` is high. At all other edges it holds its value.
- R12: The compare mode register loads `mode_in` at an edge where `mode_load` is high and otherwise holds. A capture in the same cycle as a mode load uses the previous mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | One-cycle register write strobe |
| wr_sel | input | 1 | Write target: 0 data, 1 direction |
| wr_fmt | input | 2 | Write format: 00 load, 01 set mask, 1x clear mask |
| wr_byte | input | W | Write byte or mask |
| mode_load | input | 1 | Load strobe for the compare mode |
| mode_in | input | 2 | New compare mode |
| xfer_start | input | 1 | Transfer-start pulse that captures the flag |
| pin_in | input | W | Sampled pin levels |
| rd_sel | input | 1 | Read source: 0 data, 1 direction |
| rd_data | output | W | Readback byte |
| pin_oe | output | W | Per-pin output enable |
| pin_out | output | W | Per-pin drive value |
| cmp_flag | output | 1 | Latched match flag |

## Verification
Properties check on every cycle that:
- clear writes leave the masked bits at zero and set writes leave them at one;
- the unselected register, and both registers on idle cycles, stay stable;
- output bits of a data read equal the stored value;
- the flag and the mode change only on their strobes.

Other behaviours depend on whole sequences, so only the bench scenarios can show them:
- the exact merged value after each format;
- the choice among the four compare conditions, across many direction and pin patterns;
- the use of the old mode when a load and a capture coincide.

// File: rtl/pbc_pkg.sv
`timescale 1ns/1ps
package pbc_pkg;

  typedef enum logic [1:0] {
    CMP_ANY_MISS  = 2'b00,
    CMP_ALL_MATCH = 2'b01,
    CMP_ALL_MISS  = 2'b10,
    CMP_ANY_MATCH = 2'b11
  } cmp_mode_e;

  typedef enum logic [1:0] {
    FMT_LOAD = 2'b00,
    FMT_SET  = 2'b01,
    FMT_CLR  = 2'b10,
    FMT_CLRB = 2'b11
  } wr_fmt_e;

  // Pick the condition outcome from the two reductions of the match vector.
  function automatic logic pick_cond(cmp_mode_e m, logic all_match, logic none_match);
    logic r;
    case (m)
      CMP_ANY_MISS:  r = ~all_match;
      CMP_ALL_MATCH: r = all_match;
      CMP_ALL_MISS:  r = none_match;
      default:       r = ~none_match;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/pbc_regs.sv
`timescale 1ns/1ps
module pbc_regs #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic         wr_sel,
  input  logic [1:0]   wr_fmt,
  input  logic [W-1:0] wr_byte,
  output logic [W-1:0] data_q,
  output logic [W-1:0] dir_q
);
  import pbc_pkg::*;

  localparam int NREG = 2;

  // Merge a byte into a register value under the chosen format.
  function automatic logic [W-1:0] merge(logic [W-1:0] old, logic [W-1:0] b, logic [1:0] f);
    logic [W-1:0] r;
    case (wr_fmt_e'(f))
      FMT_LOAD: r = b;
      FMT_SET:  r = old | b;
      default:  r = old & ~b;
    endcase
    return r;
  endfunction

  logic [W-1:0] regs_q [NREG];

  genvar g;
  generate
    for (g = 0; g < NREG; g++) begin : g_reg
      logic hit_w;
      assign hit_w = wr_en && (wr_sel == 1'(g));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     regs_q[g] <= '0;
        else if (hit_w) regs_q[g] <= merge(regs_q[g], wr_byte, wr_fmt);
      end
    end
  endgenerate

  assign data_q = regs_q[0];
  assign dir_q  = regs_q[1];

  logic [W-1:0] sel_q_w;
  assign sel_q_w = wr_sel ? dir_q : data_q;

  AST_LOAD_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_fmt == 2'b00) |=> (($past(wr_sel) ? dir_q : data_q) == $past(wr_byte))); // R5
  AST_CLR_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_fmt[1]) |=> ((($past(wr_sel) ? dir_q : data_q) & $past(wr_byte)) == '0)); // R6
  AST_SET_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_fmt == 2'b01) |=> ((($past(wr_sel) ? dir_q : data_q) & $past(wr_byte)) == $past(wr_byte))); // R7
  AST_KEEP_DIR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_sel) |=> $stable(dir_q)); // R8
  AST_KEEP_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel) |=> $stable(data_q)); // R8
  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(data_q) && $stable(dir_q))); // R8
  AST_MASK_UNTOUCHED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_fmt != 2'b00) |=>
      (((($past(wr_sel) ? dir_q : data_q) ^ $past(sel_q_w)) & ~$past(wr_byte)) == '0)); // R6

endmodule

// File: rtl/pbc_compare.sv
`timescale 1ns/1ps
module pbc_compare #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         mode_load,
  input  logic [1:0]   mode_in,
  input  logic         xfer_start,
  input  logic [W-1:0] data_q,
  input  logic [W-1:0] dir_q,
  input  logic [W-1:0] pin_in,
  output logic         cmp_flag
);
  import pbc_pkg::*;

  cmp_mode_e    mode_q;
  logic [W-1:0] match_w;
  logic         all_match_w;
  logic         none_match_w;
  logic         cond_w;

  // Per-bit match: output pins always match, input pins compare level to stored bit.
  genvar b;
  generate
    for (b = 0; b < W; b++) begin : g_bit
      assign match_w[b] = dir_q[b] | (pin_in[b] == data_q[b]);
    end
  endgenerate

  assign all_match_w  = &match_w;
  assign none_match_w = ~|match_w;
  assign cond_w       = pick_cond(mode_q, all_match_w, none_match_w);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         mode_q <= CMP_ANY_MISS;
    else if (mode_load) mode_q <= cmp_mode_e'(mode_in);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cmp_flag <= 1'b0;
    else if (xfer_start) cmp_flag <= cond_w;
  end

  AST_OUTPUTS_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (&dir_q) |-> all_match_w); // R9
  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer_start |=> $stable(cmp_flag)); // R11
  AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_load |=> $stable(mode_q)); // R12
  AST_ALLOUT_FULL_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_start && (&dir_q) && mode_q == CMP_ALL_MATCH) |=> cmp_flag); // R10
  AST_ALLOUT_NO_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_start && (&dir_q) && mode_q == CMP_ANY_MISS) |=> !cmp_flag); // R10

endmodule

// File: rtl/pbc_readback.sv
`timescale 1ns/1ps
module pbc_readback #(
  parameter int W = 8
) (
  input  logic         rd_sel,
  input  logic [W-1:0] data_q,
  input  logic [W-1:0] dir_q,
  input  logic [W-1:0] pin_in,
  output logic [W-1:0] rd_data
);
  logic [W-1:0] data_view_w;

  genvar b;
  generate
    for (b = 0; b < W; b++) begin : g_bit
      assign data_view_w[b] = dir_q[b] ? data_q[b] : pin_in[b];
    end
  endgenerate

  assign rd_data = rd_sel ? dir_q : data_view_w;

endmodule

// File: rtl/pin_bank_ctrl.sv
`timescale 1ns/1ps
module pin_bank_ctrl #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic         wr_sel,
  input  logic [1:0]   wr_fmt,
  input  logic [W-1:0] wr_byte,
  input  logic         mode_load,
  input  logic [1:0]   mode_in,
  input  logic         xfer_start,
  input  logic [W-1:0] pin_in,
  input  logic         rd_sel,
  output logic [W-1:0] rd_data,
  output logic [W-1:0] pin_oe,
  output logic [W-1:0] pin_out,
  output logic         cmp_flag
);
  logic [W-1:0] data_q;
  logic [W-1:0] dir_q;

  pbc_regs #(.W(W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_fmt(wr_fmt), .wr_byte(wr_byte), .data_q(data_q), .dir_q(dir_q)
  );

  pbc_compare #(.W(W)) u_cmp (
    .clk(clk), .rst_n(rst_n), .mode_load(mode_load), .mode_in(mode_in),
    .xfer_start(xfer_start), .data_q(data_q), .dir_q(dir_q),
    .pin_in(pin_in), .cmp_flag(cmp_flag)
  );

  pbc_readback #(.W(W)) u_rb (
    .rd_sel(rd_sel), .data_q(data_q), .dir_q(dir_q),
    .pin_in(pin_in), .rd_data(rd_data)
  );

  assign pin_oe  = dir_q;
  assign pin_out = data_q;

  AST_RD_OUT_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_sel |-> (((rd_data ^ pin_out) & pin_oe) == '0)); // R3
  AST_RD_IN_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_sel |-> (((rd_data ^ pin_in) & ~pin_oe) == '0)); // R3
  AST_RD_DIR: assert property (@(posedge clk) disable iff (!rst_n)
    rd_sel |-> (rd_data == pin_oe)); // R4

endmodule

// File: tb/pin_bank_ctrl_bench.sv
`timescale 1ns/1ps
module pin_bank_ctrl_bench;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         wr_en = 1'b0;
  logic         wr_sel = 1'b0;
  logic [1:0]   wr_fmt = 2'b00;
  logic [W-1:0] wr_byte = '0;
  logic         mode_load = 1'b0;
  logic [1:0]   mode_in = 2'b00;
  logic         xfer_start = 1'b0;
  logic [W-1:0] pin_in = '0;
  logic         rd_sel = 1'b0;
  logic [W-1:0] rd_data;
  logic [W-1:0] pin_oe;
  logic [W-1:0] pin_out;
  logic         cmp_flag;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [W-1:0] m_data = '0;
  logic [W-1:0] m_dir = '0;
  logic [1:0]   m_mode = 2'b00;
  logic         m_flag = 1'b0;
  logic [31:0]  lcg = 32'h1234_5678;

  always #2.5 clk = ~clk;

  pin_bank_ctrl #(.W(W)) u_pin_bank_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_fmt(wr_fmt),
    .wr_byte(wr_byte), .mode_load(mode_load), .mode_in(mode_in),
    .xfer_start(xfer_start), .pin_in(pin_in), .rd_sel(rd_sel),
    .rd_data(rd_data), .pin_oe(pin_oe), .pin_out(pin_out), .cmp_flag(cmp_flag)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  function automatic logic [7:0] rnd();
    lcg = lcg * 32'd1103515245 + 32'd12345;
    return lcg[23:16];
  endfunction

  // Bit-by-bit restatement of the three write formats.
  function automatic logic [W-1:0] bench_merge(logic [W-1:0] old, logic [W-1:0] b, logic [1:0] f);
    logic [W-1:0] r;
    for (int i = 0; i < W; i++) begin
      if (f == 2'b00)      r[i] = b[i];
      else if (b[i])       r[i] = (f == 2'b01);
      else                 r[i] = old[i];
    end
    return r;
  endfunction

  function automatic logic bench_flag(logic [1:0] md, logic [W-1:0] d, logic [W-1:0] dr, logic [W-1:0] p);
    int hits = 0;
    for (int i = 0; i < W; i++)
      if (dr[i] || (p[i] == d[i])) hits++;
    case (md)
      2'b00:   return hits < W;
      2'b01:   return hits == W;
      2'b10:   return hits == 0;
      default: return hits > 0;
    endcase
  endfunction

  function automatic logic [W-1:0] exp_view();
    logic [W-1:0] r;
    for (int i = 0; i < W; i++) r[i] = m_dir[i] ? m_data[i] : pin_in[i];
    return r;
  endfunction

  task automatic write(input logic sel, input logic [1:0] f, input logic [W-1:0] b);
    wr_en = 1'b1; wr_sel = sel; wr_fmt = f; wr_byte = b;
    step();
    wr_en = 1'b0;
    if (sel) m_dir = bench_merge(m_dir, b, f);
    else     m_data = bench_merge(m_data, b, f);
  endtask

  task automatic check_regs(input string req);
    rd_sel = 1'b1; #0.5;
    chk(rd_data == m_dir, {req, " R4 dir read"}, rd_data, m_dir);
    rd_sel = 1'b0; #0.5;
    chk(rd_data == exp_view(), {req, " R3 data read"}, rd_data, exp_view());
    chk(pin_oe == m_dir && pin_out == m_data, {req, " R2 pins"}, {pin_oe, pin_out}, {m_dir, m_data});
  endtask

  task automatic capture();
    m_flag = bench_flag(m_mode, m_data, m_dir, pin_in);
    xfer_start = 1'b1;
    step();
    xfer_start = 1'b0;
    chk(cmp_flag == m_flag, "R10 flag after capture", cmp_flag, m_flag);
  endtask

  task automatic load_mode(input logic [1:0] md);
    mode_load = 1'b1; mode_in = md;
    step();
    mode_load = 1'b0;
    m_mode = md;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual 0x0 expected 0x1");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    pin_in = 8'h5A;
    step(); step();
    rst_n = 1'b1;
    step();
    // R1 reset state
    chk(pin_oe == 8'h00 && pin_out == 8'h00, "R1 pins after reset", {pin_oe, pin_out}, 0);
    chk(cmp_flag == 1'b0, "R1 flag after reset", cmp_flag, 0);
    rd_sel = 1'b0; #0.5;
    chk(rd_data == 8'h5A, "R1 data read is pins", rd_data, 8'h5A);
    rd_sel = 1'b1; #0.5;
    chk(rd_data == 8'h00, "R1 dir read zero", rd_data, 0);
    rd_sel = 1'b0;
    // R1 default mode 00: all match gives 0, one miss gives 1
    pin_in = 8'h00; capture();
    chk(cmp_flag == 1'b0, "R1 default mode all match", cmp_flag, 0);
    pin_in = 8'h01; capture();
    chk(cmp_flag == 1'b1, "R1 default mode one miss", cmp_flag, 1);

    // Worked examples
    write(1'b1, 2'b00, 8'hFF);
    write(1'b0, 2'b00, 8'hAA);
    chk(pin_out == 8'hAA, "R5 load", pin_out, 8'hAA);
    write(1'b0, 2'b10, 8'hF0);
    chk(pin_out == 8'h0A, "R6 clear mask", pin_out, 8'h0A);
    write(1'b0, 2'b00, 8'hAA);
    write(1'b0, 2'b01, 8'hF0);
    chk(pin_out == 8'hFA, "R7 set mask", pin_out, 8'hFA);
    write(1'b0, 2'b00, 8'hAA);
    write(1'b0, 2'b11, 8'hF0);
    chk(pin_out == 8'h0A, "R6 clear mask fmt 11", pin_out, 8'h0A);
    write(1'b0, 2'b01, 8'h00);
    chk(pin_out == 8'h0A, "R7 zero mask keeps", pin_out, 8'h0A);

    // Sweep formats and targets with random bytes and pins
    for (int s = 0; s < 2; s++) begin
      for (int f = 0; f < 4; f++) begin
        for (int k = 0; k < 48; k++) begin
          pin_in = rnd();
          write(1'(s), 2'(f), rnd());
          check_regs("R5 R6 R7 R8 sweep");
        end
      end
    end

    // Idle cycles with garbage on the write bus: nothing changes (R8)
    for (int k = 0; k < 16; k++) begin
      wr_en = 1'b0; wr_sel = 1'(k); wr_fmt = 2'(k); wr_byte = rnd();
      step();
      check_regs("R8 idle");
    end

    // Compare sweep across all modes
    for (int md = 0; md < 4; md++) begin
      load_mode(2'(md));
      for (int k = 0; k < 200; k++) begin
        logic [W-1:0] dv;
        dv = (k % 5 == 0) ? 8'hFF : ((k % 7 == 0) ? 8'h00 : rnd());
        write(1'b1, 2'b00, dv);
        write(1'b0, 2'b00, rnd());
        case (k % 4)
          0: pin_in = m_data;
          1: pin_in = ~m_data;
          2: pin_in = rnd();
          default: pin_in = m_data ^ (8'h01 << (k % 8));
        endcase
        capture();                      // R9 R10
        pin_in = ~pin_in;
        write(1'b0, 2'b01, rnd());
        step();
        chk(cmp_flag == m_flag, "R11 flag held without start", cmp_flag, m_flag);
      end
    end

    // R12 same-cycle mode load and capture uses old mode
    load_mode(2'b01);
    write(1'b1, 2'b00, 8'h00);
    write(1'b0, 2'b00, 8'h3C);
    pin_in = 8'h3C;
    m_flag = bench_flag(2'b01, m_data, m_dir, pin_in);
    mode_load = 1'b1; mode_in = 2'b10; xfer_start = 1'b1;
    step();
    mode_load = 1'b0; xfer_start = 1'b0; m_mode = 2'b10;
    chk(cmp_flag == m_flag, "R12 capture uses old mode", cmp_flag, m_flag);
    capture();
    chk(cmp_flag == 1'b0, "R12 new mode after load", cmp_flag, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule